// File: doc/BRIEF.md
# Single-Channel Bus Interrupt Requester

This block turns a completed acquisition event into a prioritised bus interrupt request, then supplies an 8-bit vector when the bus master acknowledges that request. Software sets it up through a small register window. A control register holds the request level, an arm bit and a mode bit. A vector register holds the byte returned during acknowledge. A scan-length register holds the channel count used in scanning mode.

In random mode, every single-conversion completion is a request source. In scanning mode, the block counts conversion completions and raises its request only when a full scan of the programmed length has finished. The request is one-shot. When the acknowledge for it has finished, the block disarms itself, and it raises no further request until software rewrites the control register with the arm bit set. Events that arrive while the block cannot accept them are lost, and a sticky overrun flag records the loss.

The acknowledge input is daisy-chained. When an acknowledge is not meant for this block, it passes unchanged to the next device on the chain.

Top module: `irqRequester`

## Requirements
- R1: After reset, all request lines are high (inactive), the vector output enable is low, and the control, vector and scan-length registers read 0x00.
- R2: The register map is as follows. Offset 0x10 is the control register: bits 2:0 hold the level, bit 4 is arm, bit 5 selects scanning mode, bit 7 is the read-only overrun flag, and bits 3 and 6 read 0. Offset 0x14 holds the scan length in bits 5:0, and bits 7:6 read 0. Offset 0x18 is the 8-bit vector. Reads are combinational from the address, and any other offset reads 0x00.
- R3: In random mode, with the block armed and a nonzero level L, a conversion-done pulse drives request line L low from the next cycle on. At no time is more than one request line low.
- R4: A level value of 0 never raises a request, even when arm is set. An event under level 0, or while arm is clear, is dropped.
- R5: When the acknowledge input is low, the acknowledged level equals the programmed level and a request is pending, the block drives its vector on the vector output in the same cycle, raises the output enable and holds its daisy-chain output high.
- R6: Any other acknowledge is passed through: the daisy-chain output equals the daisy-chain input and the output enable stays low.
- R7: Once a served acknowledge input returns high, all request lines are high from the next cycle and the arm bit reads 0. Later events raise no request until arm is written again.
- R8: An event that arrives while a request is pending, or while the block is disarmed, sets the sticky overrun bit.
- R9: Writing the control register with bit 4 set clears overrun and re-arms the block. Writing it with bit 4 clear withdraws any pending request and leaves overrun unchanged.
- R10: In scanning mode, a scan-length value n needs n+1 conversion-done pulses to raise the request, so values 1 to 63 cover scans of 2 to 64 channels. The channel count restarts after each completed scan.
- R11: A scan-done pulse clears a partial channel count and never raises a request by itself. An arming control write also clears the channel count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 5 | Register offset for read and write |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| convDone | input | 1 | Single conversion completed (one-cycle pulse) |
| scanDone | input | 1 | Scan sequencer end marker (one-cycle pulse) |
| irqN | output | 7 | Request lines for levels 7..1, active low |
| iackInN | input | 1 | Daisy-chain acknowledge in, active low |
| iackLevel | input | 3 | Level being acknowledged |
| iackOutN | output | 1 | Daisy-chain acknowledge out, active low |
| vecOut | output | 8 | Vector for data bits 7:0 |
| vecOe | output | 1 | Vector output enable |

## Verification
Register writes and event pulses act at the next rising edge. The request lines, the arm bit and the overrun bit are therefore due one cycle after the stimulus. Vector drive, output enable, daisy-chain pass-through and register reads are combinational, so they are due within the same cycle. The bench drives inputs on the falling edge and samples registered results at the following falling edge, which puts exactly one rising edge between stimulus and check. It samples combinational results a short delay after changing the inputs, before any clock edge. Release of a served request is checked at the falling edge that follows the first rising edge seen with the acknowledge high.

// File: rtl/irqPkg.sv
package irqPkg;
  localparam int LEVEL_W    = 3;
  localparam int NUM_LEVELS = (1 << LEVEL_W) - 1;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 5;
  localparam int CNT_W      = 6;

  localparam logic [ADDR_W-1:0] CTL_OFF = 5'h10;
  localparam logic [ADDR_W-1:0] LEN_OFF = 5'h14;
  localparam logic [ADDR_W-1:0] VEC_OFF = 5'h18;

  // control register bit positions
  localparam int ARM_BIT  = 4;
  localparam int MODE_BIT = 5;
  localparam int OVR_BIT  = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic drop;
    logic complete;
  } ctlStrobes_t;

  // status from datapath to control
  typedef struct packed {
    logic               eventFire;
    logic               canAccept;
    logic               disarmWrite;
    logic [LEVEL_W-1:0] level;
  } dpStatus_t;
endpackage

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              convDone,
  input  logic              scanDone,
  input  ctlStrobes_t       strobes,
  output dpStatus_t         status,
  output logic [DATA_W-1:0] vector
);
  logic [LEVEL_W-1:0] levelReg;
  logic               armReg;
  logic               scanMode;
  logic               overrun;
  logic [DATA_W-1:0]  vectorReg;
  logic [CNT_W-1:0]   scanLen;
  logic [CNT_W-1:0]   chanCnt;

  logic wrCtl, wrLen, wrVec, armWrite, scanLast;

  assign wrCtl    = regWrEn && (regAddr == CTL_OFF);
  assign wrLen    = regWrEn && (regAddr == LEN_OFF);
  assign wrVec    = regWrEn && (regAddr == VEC_OFF);
  assign armWrite = wrCtl && regWrData[ARM_BIT];
  assign scanLast = (chanCnt == scanLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelReg  <= '0;
      armReg    <= 1'b0;
      scanMode  <= 1'b0;
      overrun   <= 1'b0;
      vectorReg <= '0;
      scanLen   <= '0;
    end else begin
      if (wrCtl) begin
        levelReg <= regWrData[LEVEL_W-1:0];
        scanMode <= regWrData[MODE_BIT];
        armReg   <= regWrData[ARM_BIT];
      end else if (strobes.complete) begin
        armReg <= 1'b0;
      end
      if (armWrite)          overrun <= 1'b0;
      else if (strobes.drop) overrun <= 1'b1;
      if (wrVec) vectorReg <= regWrData;
      if (wrLen) scanLen   <= regWrData[CNT_W-1:0];
    end
  end

  // channel counter for scanning mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    chanCnt <= '0;
    else if (armWrite || scanDone) chanCnt <= '0;
    else if (scanMode && convDone) chanCnt <= scanLast ? '0 : chanCnt + 1'b1;
  end

  always_comb begin
    status.eventFire   = convDone && (!scanMode || scanLast) && !scanDone;
    status.canAccept   = armReg && (levelReg != '0);
    status.disarmWrite = wrCtl && !regWrData[ARM_BIT];
    status.level       = levelReg;
  end

  assign vector = vectorReg;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      CTL_OFF: begin
        regRdData[LEVEL_W-1:0] = levelReg;
        regRdData[ARM_BIT]     = armReg;
        regRdData[MODE_BIT]    = scanMode;
        regRdData[OVR_BIT]     = overrun;
      end
      LEN_OFF: regRdData[CNT_W-1:0] = scanLen;
      VEC_OFF: regRdData = vectorReg;
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/irqControl.sv
module irqControl
  import irqPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStatus_t             status,
  input  logic                  iackInN,
  input  logic [LEVEL_W-1:0]    iackLevel,
  output logic                  iackOutN,
  output logic                  vecOe,
  output logic [NUM_LEVELS:1]   irqN,
  output ctlStrobes_t           strobes
);
  logic pending;
  logic servicing;
  logic ackHit;
  logic accept;

  assign ackHit = !iackInN && pending && (iackLevel == status.level);
  assign accept = status.eventFire && status.canAccept && !pending;

  always_comb begin
    strobes.drop     = status.eventFire && !accept;
    strobes.complete = servicing && iackInN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= 1'b0;
      servicing <= 1'b0;
    end else begin
      if (status.disarmWrite || strobes.complete) pending <= 1'b0;
      else if (accept)                            pending <= 1'b1;
      if (status.disarmWrite || strobes.complete) servicing <= 1'b0;
      else if (ackHit)                            servicing <= 1'b1;
    end
  end

  assign vecOe    = ackHit;
  assign iackOutN = ackHit ? 1'b1 : iackInN;

  for (genvar lv = 1; lv <= NUM_LEVELS; lv++) begin : g_line
    assign irqN[lv] = !(pending && (status.level == LEVEL_W'(lv)));
  end
endmodule

// File: rtl/irqRequester.sv
module irqRequester
  import irqPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic                convDone,
  input  logic                scanDone,
  output logic [NUM_LEVELS:1] irqN,
  input  logic                iackInN,
  input  logic [LEVEL_W-1:0]  iackLevel,
  output logic                iackOutN,
  output logic [DATA_W-1:0]   vecOut,
  output logic                vecOe
);
  ctlStrobes_t strobes;
  dpStatus_t   status;
  logic [DATA_W-1:0] vector;

  irqDatapath uDp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .convDone(convDone),
    .scanDone(scanDone), .strobes(strobes), .status(status), .vector(vector)
  );

  irqControl uCtl (
    .clk(clk), .rstN(rstN), .status(status), .iackInN(iackInN),
    .iackLevel(iackLevel), .iackOutN(iackOutN), .vecOe(vecOe),
    .irqN(irqN), .strobes(strobes)
  );

  assign vecOut = vecOe ? vector : '0;
endmodule

// File: rtl/irqRequesterChecker.sv
module irqRequesterChecker
  import irqPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [NUM_LEVELS:1] irqN,
  input logic                iackInN,
  input logic [LEVEL_W-1:0]  iackLevel,
  input logic                iackOutN,
  input logic                vecOe
);
  logic [NUM_LEVELS:0] lines;
  assign lines = {irqN, 1'b1};

  assert_one_line_R3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~irqN) <= 1);

  assert_ack_blocks_chain_R5: assert property (@(posedge clk) disable iff (!rstN)
    vecOe |-> (iackOutN && !iackInN));

  assert_ack_on_own_line_R5: assert property (@(posedge clk) disable iff (!rstN)
    vecOe |-> (lines[iackLevel] == 1'b0));

  assert_pass_through_R6: assert property (@(posedge clk) disable iff (!rstN)
    !vecOe |-> (iackOutN == iackInN));

  assert_release_after_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(iackInN) && $past(vecOe)) |=> (irqN == '1));
endmodule

bind irqRequester irqRequesterChecker uChk (
  .clk(clk), .rstN(rstN), .irqN(irqN), .iackInN(iackInN),
  .iackLevel(iackLevel), .iackOutN(iackOutN), .vecOe(vecOe)
);

// File: tb/sim_irqRequester.sv
module sim_irqRequester;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // fields: level[17:15] scanMode[14] scanLen[13:8] pulses[7:1] expectReq[0]
  localparam logic [17:0] VECS [NVEC] = '{
    {3'd3, 1'b0, 6'd0,  7'd1,  1'b1},
    {3'd7, 1'b0, 6'd0,  7'd1,  1'b1},
    {3'd2, 1'b1, 6'd3,  7'd3,  1'b0},
    {3'd2, 1'b1, 6'd3,  7'd4,  1'b1},
    {3'd5, 1'b1, 6'd63, 7'd64, 1'b1},
    {3'd1, 1'b1, 6'd1,  7'd1,  1'b0},
    {3'd0, 1'b0, 6'd0,  7'd1,  1'b0}
  };

  logic clk = 0, rstN = 0;
  logic [4:0] regAddr = 0;
  logic regWrEn = 0;
  logic [7:0] regWrData = 0;
  logic [7:0] regRdData;
  logic convDone = 0, scanDone = 0;
  logic [7:1] irqN;
  logic iackInN = 1;
  logic [2:0] iackLevel = 0;
  logic iackOutN;
  logic [7:0] vecOut;
  logic vecOe;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqRequester u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic pulseConv();
    convDone = 1; @(negedge clk); convDone = 0;
  endtask

  function automatic logic [7:1] expLines(input logic [2:0] lv, input logic req);
    logic [7:1] e = '1;
    if (req && lv != 0) e[lv] = 1'b0;
    return e;
  endfunction

  // serve an acknowledge for level lv, checking vector v
  task automatic serve(input string req, input logic [2:0] lv, input logic [7:0] v);
    logic [7:0] d;
    iackLevel = lv; iackInN = 0; #1;
    check({req, " vecOe"}, vecOe, 1);
    check({req, " vector"}, vecOut, v);
    check({req, " chain held"}, iackOutN, 1);
    @(negedge clk);
    iackInN = 1;
    @(negedge clk);
    check("R7 released", irqN, 7'h7f);
    rd(5'h10, d);
    check("R7 arm cleared", d[4], 0);
  endtask

  initial begin
    logic [7:0] d;
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 irqN", irqN, 7'h7f);
    check("R1 vecOe", vecOe, 0);
    rd(5'h10, d); check("R1 ctl", d, 0);
    rd(5'h18, d); check("R1 vec", d, 0);
    rd(5'h14, d); check("R1 len", d, 0);
    rstN = 1;
    @(negedge clk);

    // table walk: R3 R4 R5 R10
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] lv = VECS[i][17:15];
      logic md = VECS[i][14];
      logic [5:0] ln = VECS[i][13:8];
      int np = int'(VECS[i][7:1]);
      logic ex = VECS[i][0];
      wr(5'h10, 8'h00);
      wr(5'h14, {2'b00, ln});
      wr(5'h18, 8'h40 + 8'(i));
      wr(5'h10, {2'b00, md, 1'b1, 1'b0, lv});
      for (int p = 0; p < np; p++) pulseConv();
      check(md ? "R10 scan request" : (lv == 0 ? "R4 level zero" : "R3 random request"),
            irqN, expLines(lv, ex));
      if (ex) serve("R5", lv, 8'h40 + 8'(i));
    end

    // R8 overrun while pending, R6 pass-through, R7 one-shot, R9 rearm
    wr(5'h10, 8'h00);
    wr(5'h18, 8'hA5);
    wr(5'h10, 8'h14);
    pulseConv();
    check("R3 level4", irqN, 7'b1110111);
    pulseConv();
    rd(5'h10, d); check("R8 overrun while pending", d, 8'h94);
    iackLevel = 3'd2; iackInN = 0; #1;
    check("R6 pass chain", iackOutN, 0);
    check("R6 no drive", vecOe, 0);
    @(negedge clk); iackInN = 1; #1;
    check("R6 pass high", iackOutN, 1);
    check("R6 still pending", irqN, 7'b1110111);
    serve("R5", 3'd4, 8'hA5);
    rd(5'h10, d); check("R8 overrun sticky", d, 8'h84);
    pulseConv();
    check("R7 one-shot silent", irqN, 7'h7f);
    wr(5'h10, 8'h14);
    rd(5'h10, d); check("R9 clear overrun", d, 8'h14);
    pulseConv();
    check("R9 rearmed request", irqN, 7'b1110111);
    wr(5'h10, 8'h04);
    check("R9 disarm withdraws", irqN, 7'h7f);
    pulseConv();
    rd(5'h10, d); check("R8 overrun disarmed", d, 8'h84);

    // R11 scanDone clears partial count
    wr(5'h14, 8'h02);
    wr(5'h10, 8'h36);
    pulseConv(); pulseConv();
    scanDone = 1; @(negedge clk); scanDone = 0;
    check("R11 scanDone no request", irqN, 7'h7f);
    pulseConv(); pulseConv();
    check("R11 count restarted", irqN, 7'h7f);
    pulseConv();
    check("R11 full scan request", irqN, 7'b1011111);
    wr(5'h10, 8'h00);

    // R2 register map
    wr(5'h10, 8'hFF);
    rd(5'h10, d); check("R2 ctl mask", d, 8'h37);
    wr(5'h14, 8'hFF);
    rd(5'h14, d); check("R2 len mask", d, 8'h3F);
    rd(5'h00, d); check("R2 unmapped", d, 8'h00);
    wr(5'h10, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule